// File: doc/BRIEF.md
# Programmable Command Setup Timer

This block sets how long a card-bus access waits, in internal clocks, before its command strobe goes active. The same wait applies to memory read, memory write, I/O read and I/O write. Two setup registers sit behind a small indexed register port. Each holds an 8-bit value. The upper two bits of that value pick a non-linear weight and the lower six bits give a multiplier. The wait is the weight times the multiplier, plus one.

When a cycle-start request is sampled, the `set_sel` input picks one of the two registers. The block loads a down-counter with the computed length and raises `cmd_en` once that many clocks have passed. `cmd_en` stays high until a cycle-end request arrives. A register write is stored on the same edge that samples it, so the next cycle uses the new value.

The control is a three-state machine:
- `ST_IDLE` waits for a start.
- `ST_COUNT` runs the setup count.
- `ST_CMD` holds the command enable.

Its transitions are:
- `T_LAUNCH`: `ST_IDLE` to `ST_COUNT`, on `cyc_start`.
- `T_EXPIRE`: `ST_COUNT` to `ST_CMD`, when the count reaches its last clock.
- `T_ABORT`: `ST_COUNT` to `ST_IDLE`, on `cyc_end`.
- `T_RELEASE`: `ST_CMD` to `ST_IDLE`, on `cyc_end`.

Top module: `cmd_setup_timer`

## Requirements
- R1: After reset, both setup registers read 8'h01 and `cmd_en` is low.
- R2: In a setup value, bits 7:6 select the weight (00 gives 1, 01 gives 16, 10 gives 256, 11 gives 8192) and bits 5:0 give the multiplier M. The setup length L is weight × M + 1.
- R3: Let edge 0 be the rising clock edge that samples `cyc_start` high in idle. `cmd_en` goes high right after edge L and is low before it.
- R4: `set_sel` is sampled at edge 0. Value 0 selects the register at index 8'h3A and value 1 selects the register at index 8'h3D.
- R5: A write with `reg_wr_en` high to index 8'h3A or 8'h3D stores `reg_wdata` at that edge. A start sampled at the same edge uses the value held before the write; later starts use the new value.
- R6: `reg_rdata` combinationally returns the stored value for index 8'h3A or 8'h3D, and 0 for any other index. Writes to other indexes change neither register.
- R7: Once high, `cmd_en` stays high until an edge samples `cyc_end` high, and is low right after that edge.
- R8: `cyc_start` sampled while counting or while `cmd_en` is high is ignored. It neither restarts the count nor starts a new cycle.
- R9: `cyc_end` sampled while counting abandons the setup. The block returns to idle and `cmd_en` stays low.
- R10: `cyc_end` in idle has no effect. When `cyc_start` and `cyc_end` are both high in idle, the start is taken.
- R11: A multiplier of 0 gives a one-clock setup for every weight code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_idx | input | 8 | Register index for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_idx` |
| set_sel | input | 1 | Timing set selected for the next start |
| cyc_start | input | 1 | Cycle start request |
| cyc_end | input | 1 | Cycle end request |
| cmd_en | output | 1 | Command strobe enable |

## Verification
The assertions assume that all inputs are synchronous and stable around each rising edge. They also assume that a start-to-enable interval is always as long as the programmed length loaded at launch. This holds because a register write never reaches a count that is already running.

The bench drives every input on the falling edge and holds each start and end request for exactly one clock. It keeps the programmed lengths short enough to finish in the cycle budget, so the largest weight is used only with small multipliers.

// File: rtl/cst_pkg.sv
package cst_pkg;
    localparam int MULT_W    = 6;
    localparam int CODE_W    = 2;
    localparam int MAX_SHIFT = 13;
    localparam int REG_W     = CODE_W + MULT_W;
    localparam int IDX_W     = 8;
    localparam int CNT_W     = MULT_W + MAX_SHIFT;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_CMD   = 2'd2
    } tmr_state_e;
endpackage

// File: rtl/cst_regfile.sv
module cst_regfile #(
    parameter int REG_W    = 8,
    parameter int IDX_W    = 8,
    parameter int NUM_SETS = 2,
    parameter logic [NUM_SETS*IDX_W-1:0] SET_IDX = {8'h3D, 8'h3A},
    parameter logic [REG_W-1:0] RST_VAL = 8'h01
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          idx,
    input  logic [REG_W-1:0]          wdata,
    output logic [REG_W-1:0]          rdata,
    output logic [NUM_SETS*REG_W-1:0] regs_flat
);
    logic [REG_W-1:0] set_q [NUM_SETS];

    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
        localparam logic [IDX_W-1:0] MY_IDX = SET_IDX[g*IDX_W +: IDX_W];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                set_q[g] <= RST_VAL;
            end else if (wr_en && idx == MY_IDX) begin
                set_q[g] <= wdata;
            end
        end
        assign regs_flat[g*REG_W +: REG_W] = set_q[g];

        // R5
        set_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && idx == MY_IDX) |=> (set_q[g] == $past(wdata)));

        // R6
        foreign_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (idx != MY_IDX) |=> $stable(set_q[g]));
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_SETS; i++) begin
            if (idx == SET_IDX[i*IDX_W +: IDX_W]) begin
                rdata = set_q[i];
            end
        end
    end
endmodule

// File: rtl/cst_len_calc.sv
module cst_len_calc #(
    parameter int MULT_W = 6,
    parameter int CODE_W = 2,
    parameter int CNT_W  = 19
) (
    input  logic [CODE_W+MULT_W-1:0] setup_val,
    output logic [CNT_W-1:0]         len
);
    logic [CODE_W-1:0] code;
    logic [CNT_W-1:0]  mult_ext;
    logic [CNT_W-1:0]  scaled;

    assign code     = setup_val[CODE_W+MULT_W-1 -: CODE_W];
    assign mult_ext = CNT_W'(setup_val[MULT_W-1:0]);

    // R2: weights 1, 16, 256, 8192 as left shifts
    always_comb begin
        unique case (code)
            2'b00:   scaled = mult_ext;
            2'b01:   scaled = mult_ext << 4;
            2'b10:   scaled = mult_ext << 8;
            2'b11:   scaled = mult_ext << 13;
            default: scaled = mult_ext;
        endcase
        len = scaled + CNT_W'(1);
    end
endmodule

// File: rtl/cst_fsm.sv
module cst_fsm
    import cst_pkg::*;
#(
    parameter int CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_start,
    input  logic             cyc_end,
    input  logic [CNT_W-1:0] load_len,
    output logic             cmd_en
);
    tmr_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (cyc_start) st_d = ST_COUNT;              // T_LAUNCH
            ST_COUNT: begin
                if (cyc_end)                   st_d = ST_IDLE;     // T_ABORT
                else if (cnt_q == CNT_W'(1))   st_d = ST_CMD;      // T_EXPIRE
            end
            ST_CMD:   if (cyc_end) st_d = ST_IDLE;                 // T_RELEASE
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (st_q == ST_IDLE && cyc_start) begin
            cnt_q <= load_len;
        end else if (st_q == ST_COUNT) begin
            if (cyc_end) cnt_q <= '0;
            else         cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    always_comb begin
        cmd_en = (st_q == ST_CMD);
    end

    // R3
    launch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && cyc_start) |=> (st_q == ST_COUNT && cnt_q == $past(load_len)));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COUNT && !cyc_end && cnt_q != CNT_W'(1)) |=>
            (st_q == ST_COUNT && cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R3
    enable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_en) |-> ($past(st_q) == ST_COUNT && $past(cnt_q) == CNT_W'(1)));

    // R3
    count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COUNT) |-> (cnt_q != '0));

    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_en && cyc_end) |=> !cmd_en);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_en && !cyc_end) |=> cmd_en);

    // R9
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COUNT && cyc_end) |=> (st_q == ST_IDLE && !cmd_en));
endmodule

// File: rtl/cmd_setup_timer.sv
module cmd_setup_timer
    import cst_pkg::*;
#(
    parameter int          SETUP_MULT_W = MULT_W,
    parameter int          SETUP_CODE_W = CODE_W,
    parameter int          INDEX_W      = IDX_W,
    parameter logic [7:0]  SET0_INDEX   = 8'h3A,
    parameter logic [7:0]  SET1_INDEX   = 8'h3D
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                reg_wr_en,
    input  logic [INDEX_W-1:0]                  reg_idx,
    input  logic [SETUP_CODE_W+SETUP_MULT_W-1:0] reg_wdata,
    output logic [SETUP_CODE_W+SETUP_MULT_W-1:0] reg_rdata,
    input  logic                                set_sel,
    input  logic                                cyc_start,
    input  logic                                cyc_end,
    output logic                                cmd_en
);
    localparam int RW     = SETUP_CODE_W + SETUP_MULT_W;
    localparam int NSETS  = 2;
    localparam int LEN_W  = SETUP_MULT_W + MAX_SHIFT;
    localparam logic [NSETS*INDEX_W-1:0] IDX_LIST =
        {INDEX_W'(SET1_INDEX), INDEX_W'(SET0_INDEX)};
    localparam logic [RW-1:0] RESET_VAL = RW'(1);

    logic [NSETS*RW-1:0] regs_flat;
    logic [LEN_W-1:0]    len_of_set [NSETS];
    logic [LEN_W-1:0]    sel_len;

    cst_regfile #(
        .REG_W    (RW),
        .IDX_W    (INDEX_W),
        .NUM_SETS (NSETS),
        .SET_IDX  (IDX_LIST),
        .RST_VAL  (RESET_VAL)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .idx       (reg_idx),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .regs_flat (regs_flat)
    );

    for (genvar g = 0; g < NSETS; g++) begin : g_len
        cst_len_calc #(
            .MULT_W (SETUP_MULT_W),
            .CODE_W (SETUP_CODE_W),
            .CNT_W  (LEN_W)
        ) calc_i (
            .setup_val (regs_flat[g*RW +: RW]),
            .len       (len_of_set[g])
        );
    end

    // R4: set 0 when set_sel is low, set 1 when high
    assign sel_len = set_sel ? len_of_set[1] : len_of_set[0];

    cst_fsm #(
        .CNT_W (LEN_W)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .cyc_end   (cyc_end),
        .load_len  (sel_len),
        .cmd_en    (cmd_en)
    );
endmodule

// File: tb/cmd_setup_timer_tb.sv
module cmd_setup_timer_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG_CYC = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_idx = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       set_sel = 1'b0;
    logic       cyc_start = 1'b0;
    logic       cyc_end = 1'b0;
    logic       cmd_en;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_setup_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .set_sel   (set_sel),
        .cyc_start (cyc_start),
        .cyc_end   (cyc_end),
        .cmd_en    (cmd_en)
    );

    function automatic int exp_len(input logic [7:0] v);
        int w;
        case (v[7:6])
            2'b00: w = 1;
            2'b01: w = 16;
            2'b10: w = 256;
            default: w = 8192;
        endcase
        return w * int'(v[5:0]) + 1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] idx, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] idx, output int v);
        @(negedge clk);
        reg_idx = idx;
        #1;
        v = int'(reg_rdata);
    endtask

    // Pulse start for one clock, return clocks from launch edge to cmd_en high.
    task automatic launch_measure(input logic sel, input int limit, output int n);
        @(negedge clk);
        cyc_start = 1'b1; set_sel = sel;
        @(negedge clk);
        cyc_start = 1'b0;
        n = 0;
        while (!cmd_en && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic end_cycle();
        cyc_end = 1'b1;
        @(negedge clk);
        cyc_end = 1'b0;
    endtask

    task automatic t_reset();
        int v;
        check("R1 cmd_en after reset", int'(cmd_en), 0);
        rd_reg(8'h3A, v); check("R1 set0 reset value", v, 1);
        rd_reg(8'h3D, v); check("R1 set1 reset value", v, 1);
    endtask

    task automatic t_default_len();
        int n;
        launch_measure(1'b0, 100, n);
        check("R3 default length set0", n, 2);
        end_cycle();
        check("R7 cmd_en low after end", int'(cmd_en), 0);
    endtask

    task automatic t_weights();
        logic [7:0] vals [6] = '{8'h05, 8'h43, 8'h82, 8'hC2, 8'h3F, 8'h7F};
        int n;
        foreach (vals[i]) begin
            wr_reg(8'h3A, vals[i]);
            launch_measure(1'b0, 20000, n);
            check($sformatf("R2 R3 length for 0x%02h", vals[i]), n, exp_len(vals[i]));
            end_cycle();
        end
    endtask

    task automatic t_zero_mult();
        int n;
        for (int c = 0; c < 4; c++) begin
            wr_reg(8'h3D, 8'(c << 6));
            launch_measure(1'b1, 100, n);
            check($sformatf("R11 zero multiplier code %0d", c), n, 1);
            end_cycle();
        end
    endtask

    task automatic t_select_and_read();
        int n, v;
        wr_reg(8'h3A, 8'h04);
        wr_reg(8'h3D, 8'h09);
        rd_reg(8'h3A, v); check("R6 read set0", v, 8'h04);
        rd_reg(8'h3D, v); check("R6 read set1", v, 8'h09);
        rd_reg(8'h3B, v); check("R6 read other index", v, 0);
        wr_reg(8'h3C, 8'hFF);
        wr_reg(8'h00, 8'hFF);
        rd_reg(8'h3A, v); check("R6 set0 unchanged by foreign write", v, 8'h04);
        rd_reg(8'h3D, v); check("R6 set1 unchanged by foreign write", v, 8'h09);
        launch_measure(1'b0, 100, n); check("R4 select set0", n, 5);
        end_cycle();
        launch_measure(1'b1, 100, n); check("R4 select set1", n, 10);
        end_cycle();
    endtask

    task automatic t_same_edge_write();
        int n;
        wr_reg(8'h3A, 8'h06);
        @(negedge clk);
        cyc_start = 1'b1; set_sel = 1'b0;
        reg_wr_en = 1'b1; reg_idx = 8'h3A; reg_wdata = 8'h02;
        @(negedge clk);
        cyc_start = 1'b0; reg_wr_en = 1'b0;
        n = 0;
        while (!cmd_en && n < 100) begin @(negedge clk); n++; end
        check("R5 start uses value before same-edge write", n, 7);
        end_cycle();
        launch_measure(1'b0, 100, n);
        check("R5 next start uses new value", n, 3);
        end_cycle();
    endtask

    task automatic t_hold_and_ignore_start();
        int n;
        bit rose;
        wr_reg(8'h3A, 8'h08);
        wr_reg(8'h3D, 8'h01);
        // start pulse mid-count with other set selected
        @(negedge clk);
        cyc_start = 1'b1; set_sel = 1'b0;
        @(negedge clk);
        cyc_start = 1'b0;
        @(negedge clk); @(negedge clk);
        cyc_start = 1'b1; set_sel = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
        n = 3;
        while (!cmd_en && n < 100) begin @(negedge clk); n++; end
        check("R8 start during count ignored", n, 9);
        // hold for several clocks, with a start pulse while high
        cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
        for (int k = 0; k < 5; k++) @(negedge clk);
        check("R7 cmd_en held high", int'(cmd_en), 1);
        end_cycle();
        rose = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (cmd_en) rose = 1'b1;
        end
        check("R8 start while active starts no cycle", int'(rose), 0);
    endtask

    task automatic t_abort();
        bit rose;
        wr_reg(8'h3A, 8'h06);
        @(negedge clk);
        cyc_start = 1'b1; set_sel = 1'b0;
        @(negedge clk);
        cyc_start = 1'b0;
        @(negedge clk);
        end_cycle();
        rose = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (cmd_en) rose = 1'b1;
        end
        check("R9 end during count abandons setup", int'(rose), 0);
    endtask

    task automatic t_idle_end();
        int n;
        bit rose;
        wr_reg(8'h3A, 8'h03);
        @(negedge clk);
        end_cycle();
        rose = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (cmd_en) rose = 1'b1;
        end
        check("R10 end in idle has no effect", int'(rose), 0);
        @(negedge clk);
        cyc_start = 1'b1; cyc_end = 1'b1; set_sel = 1'b0;
        @(negedge clk);
        cyc_start = 1'b0; cyc_end = 1'b0;
        n = 0;
        while (!cmd_en && n < 100) begin @(negedge clk); n++; end
        check("R10 start wins over end in idle", n, 4);
        end_cycle();
    endtask

    initial begin : watchdog
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_default_len();
        t_weights();
        t_zero_mult();
        t_select_and_read();
        t_same_edge_write();
        t_hold_and_ignore_start();
        t_abort();
        t_idle_end();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule